// File: doc/BRIEF.md
# Duty-Cycle Line Bit Decoder

This block turns a single-wire input, on which each bit is a pulse of fixed period with a variable high time, into ordinary digital bits. Every bit begins with a rising edge. A long high pulse, about three quarters of the period, stands for a one. A short high pulse, about a quarter of the period, stands for a zero. The line is brought into the system clock domain and its rising edges are found. A one-shot timer is restarted at each edge and takes one sample of the line half a bit period later. Because the timer depends only on edges, the stream may stop and restart at any point.

The sample delay follows the incoming rate. The edge-to-edge distance is measured for every bit, and plausible measurements are averaged over a fixed window of bits to form the calibrated period. Each decoded bit is given out at once as a one-cycle strobe with a data level, in the manner of a serial clock and data pair. Bits are also packed into bytes and placed in a small read-side FIFO. The block does no framing: idle bits are decoded like any others.

Top module: `pwm_bit_decoder`

## Requirements
- R1: Each rising edge of `line_i` starts a bit. The bit value is the line level sampled half a calibrated period after that edge: high gives 1 and low gives 0. A one is about 75% high and a zero is about 25% high.
- R2: Each decoded bit produces exactly one single-cycle pulse on `bit_clk_o`, with `bit_dat_o` carrying the bit value in that cycle. Bits appear in the order received.
- R3: Decoded bits are packed into bytes, first received bit into bit 7. Every eighth bit pushes the completed byte into the FIFO.
- R4: The FIFO holds 16 bytes and releases them in arrival order. `rd_data_o` shows the oldest byte whenever `rd_empty_o` is low. A cycle with `rd_en_i` high removes that byte. `rd_full_o` is high when 16 bytes are held.
- R5: A byte completed while the FIFO is full is discarded and sets `overflow_o`. The flag stays set until reset, and the stored bytes are unchanged.
- R6: The distance between consecutive rising edges of one burst, in clock cycles, is a measurement. It is accepted only if it lies between 50% and 150% of the nominal period, inclusive.
- R7: After reset the calibrated period equals the nominal period (100 cycles). Each group of 8 accepted measurements replaces it with their average. A group of fewer than 8 leaves it unchanged.
- R8: A rejected measurement changes neither the calibrated period nor the partial group.
- R9: If no rising edge arrives for 2 nominal periods, `line_idle_o` goes high and any partial measurement group is dropped. The next rising edge clears the flag. The first edge after idle gives no measurement, and a partly filled byte is kept.
- R10: After reset, `line_idle_o` is high, `rd_empty_o` is high, `rd_full_o`, `overflow_o` and `bit_clk_o` are low, and `cal_period_o` is 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 100 cycles per nominal bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Raw duty-cycle-coded line, asynchronous |
| bit_clk_o | output | 1 | One-cycle strobe per decoded bit |
| bit_dat_o | output | 1 | Decoded bit value, valid with the strobe |
| line_idle_o | output | 1 | No edge seen for two nominal periods |
| cal_period_o | output | 8 | Calibrated bit period in clock cycles |
| rd_en_i | input | 1 | Remove the oldest byte from the FIFO |
| rd_data_o | output | 8 | Oldest byte in the FIFO |
| rd_empty_o | output | 1 | FIFO holds no byte |
| rd_full_o | output | 1 | FIFO holds 16 bytes |
| overflow_o | output | 1 | Sticky: a byte was lost to a full FIFO |

## Verification
The hardest state to reach is the boundary of the calibration window. The calibrated period must stay put after seven accepted measurements at a new rate and move after eight. This depends on the first edge of each burst giving no measurement and on the idle gap clearing the group. The stimulus sends a burst of eight bits at 80 cycles, so seven measurements are made and the group is dropped at idle. A burst of nine bits at 80 cycles follows, then bursts at 120 and 170 cycles. These show tracking, sampling with the old half-period on the first bits of a new rate, and rejection of out-of-range periods.

// File: rtl/pwmdec_pkg.sv
package pwmdec_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] dec_byte_t;

    // serial-to-byte packer and strobe register state
    typedef struct packed {
        dec_byte_t              shift;
        logic [BIT_IDX_W-1:0]   nbits;
        logic                   push;
        dec_byte_t              push_byte;
        logic                   strobe;
        logic                   dat;
    } pack_state_t;

endpackage

// File: rtl/pwmdec_sync_edge.sv
module pwmdec_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s_o,
    output logic rise_o
);

    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], line_i};
        d.prev = q.sync[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_s_o = q.sync[1];
    assign rise_o   = q.sync[1] & ~q.prev;

    // a detected edge never lasts longer than one cycle
    assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pwmdec_period_track.sv
module pwmdec_period_track #(
    parameter int NOM_CYCLES = 100,
    parameter int CAL_LOG2   = 3,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic             line_i,
    output logic             bit_v_o,
    output logic             bit_val_o,
    output logic             idle_o,
    output logic [CNT_W-1:0] period_o
);

    localparam int SUM_W = CNT_W + CAL_LOG2;
    localparam logic [CNT_W-1:0] NOM_C  = CNT_W'(NOM_CYCLES);
    localparam logic [CNT_W-1:0] LO_C   = CNT_W'(NOM_CYCLES / 2);
    localparam logic [CNT_W-1:0] HI_C   = CNT_W'(NOM_CYCLES + NOM_CYCLES / 2);
    localparam logic [CNT_W-1:0] IDLE_C = CNT_W'(2 * NOM_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [CNT_W-1:0]    per;
        logic [SUM_W-1:0]    acc;
        logic [CAL_LOG2-1:0] nacc;
        logic                armed;
        logic                idle;
        logic                bit_v;
        logic                bit_val;
    } trk_t;

    trk_t q, d;
    logic [CNT_W-1:0] half;
    logic             in_range;
    logic [SUM_W-1:0] sum_new;

    always_comb begin
        d        = q;
        d.bit_v  = 1'b0;
        half     = q.per >> 1;
        in_range = (q.cnt >= LO_C) && (q.cnt <= HI_C);
        sum_new  = q.acc + SUM_W'(q.cnt);
        if (rise_i) begin
            d.cnt   = CNT_W'(1);
            d.armed = 1'b1;
            d.idle  = 1'b0;
            if (!q.idle && in_range) begin
                if (q.nacc == '1) begin
                    d.per  = sum_new[CAL_LOG2 +: CNT_W];
                    d.acc  = '0;
                    d.nacc = '0;
                end else begin
                    d.acc  = sum_new;
                    d.nacc = q.nacc + CAL_LOG2'(1);
                end
            end
        end else begin
            if (q.cnt != IDLE_C)
                d.cnt = q.cnt + CNT_W'(1);
            if (q.armed && (q.cnt == half)) begin
                d.bit_v   = 1'b1;
                d.bit_val = line_i;
                d.armed   = 1'b0;
            end
            if (q.cnt == IDLE_C - CNT_W'(1)) begin
                d.idle  = 1'b1;
                d.armed = 1'b0;
                d.acc   = '0;
                d.nacc  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.per   <= NOM_C;
            q.idle  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign bit_v_o   = q.bit_v;
    assign bit_val_o = q.bit_val;
    assign idle_o    = q.idle;
    assign period_o  = q.per;

    assert_period_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (period_o >= LO_C) && (period_o <= HI_C));

    assert_edge_clears_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> !idle_o);

    assert_one_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_v_o |=> !bit_v_o);

endmodule

// File: rtl/pwmdec_byte_fifo.sv
module pwmdec_byte_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  pwmdec_pkg::dec_byte_t push_data_i,
    input  logic                  pop_i,
    output pwmdec_pkg::dec_byte_t head_o,
    output logic                  empty_o,
    output logic                  full_o,
    output logic                  ovf_o
);

    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   count;
        logic          ovf;
    } fifo_t;

    fifo_t q, d;
    pwmdec_pkg::dec_byte_t mem [DEPTH];
    logic push_ok, pop_ok, is_full, is_empty;

    always_comb begin
        is_full  = (q.count == (AW+1)'(DEPTH));
        is_empty = (q.count == '0);
        pop_ok   = pop_i && !is_empty;
        push_ok  = push_i && (!is_full || pop_ok);
        d        = q;
        if (push_ok) d.wp = q.wp + AW'(1);
        if (pop_ok)  d.rp = q.rp + AW'(1);
        if (push_ok && !pop_ok)      d.count = q.count + (AW+1)'(1);
        else if (pop_ok && !push_ok) d.count = q.count - (AW+1)'(1);
        if (push_i && !push_ok) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= push_data_i;
    end

    assign head_o  = mem[q.rp];
    assign empty_o = is_empty;
    assign full_o  = is_full;
    assign ovf_o   = q.ovf;

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= (AW+1)'(DEPTH));

    assert_not_full_and_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    assert_overflow_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

endmodule

// File: rtl/pwm_bit_decoder.sv
module pwm_bit_decoder #(
    parameter int NOM_CYCLES = 100,
    parameter int CAL_LOG2   = 3,
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(2 * NOM_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_i,
    output logic             bit_clk_o,
    output logic             bit_dat_o,
    output logic             line_idle_o,
    output logic [CNT_W-1:0] cal_period_o,
    input  logic             rd_en_i,
    output logic [7:0]       rd_data_o,
    output logic             rd_empty_o,
    output logic             rd_full_o,
    output logic             overflow_o
);
    import pwmdec_pkg::*;

    logic line_s, rise, bit_v, bit_val;

    pwmdec_sync_edge u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .line_s_o (line_s),
        .rise_o   (rise)
    );

    pwmdec_period_track #(
        .NOM_CYCLES (NOM_CYCLES),
        .CAL_LOG2   (CAL_LOG2),
        .CNT_W      (CNT_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .line_i    (line_s),
        .bit_v_o   (bit_v),
        .bit_val_o (bit_val),
        .idle_o    (line_idle_o),
        .period_o  (cal_period_o)
    );

    pack_state_t pk_q, pk_d;

    always_comb begin
        pk_d        = pk_q;
        pk_d.push   = 1'b0;
        pk_d.strobe = bit_v;
        if (bit_v) begin
            pk_d.dat   = bit_val;
            pk_d.shift = {pk_q.shift[BYTE_W-2:0], bit_val};
            if (pk_q.nbits == BIT_IDX_W'(BYTE_W - 1)) begin
                pk_d.push      = 1'b1;
                pk_d.push_byte = {pk_q.shift[BYTE_W-2:0], bit_val};
                pk_d.nbits     = '0;
            end else begin
                pk_d.nbits = pk_q.nbits + BIT_IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign bit_clk_o = pk_q.strobe;
    assign bit_dat_o = pk_q.dat;

    pwmdec_byte_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (pk_q.push),
        .push_data_i (pk_q.push_byte),
        .pop_i       (rd_en_i),
        .head_o      (rd_data_o),
        .empty_o     (rd_empty_o),
        .full_o      (rd_full_o),
        .ovf_o       (overflow_o)
    );

    // a byte push always comes with the strobe of its last bit
    assert_push_with_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.push |-> bit_clk_o);

endmodule

// File: tb/pwm_bit_decoder_tb.sv
module pwm_bit_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic       bit_clk_o, bit_dat_o, line_idle_o;
    logic [7:0] cal_period_o;
    logic [7:0] rd_data_o;
    logic       rd_empty_o, rd_full_o, overflow_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit exp_bits [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bit_decoder u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .bit_clk_o    (bit_clk_o),
        .bit_dat_o    (bit_dat_o),
        .line_idle_o  (line_idle_o),
        .cal_period_o (cal_period_o),
        .rd_en_i      (rd_en_i),
        .rd_data_o    (rd_data_o),
        .rd_empty_o   (rd_empty_o),
        .rd_full_o    (rd_full_o),
        .overflow_o   (overflow_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the next queued bit (R1 value, R2 order)
    always @(negedge clk) begin
        if (rst_n && bit_clk_o) begin
            n_checks++;
            if (exp_bits.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected strobe actual=%0d expected=none", bit_dat_o);
            end else begin
                bit e;
                e = exp_bits.pop_front();
                if (bit_dat_o !== e) begin
                    n_fail++;
                    $display("FAIL R1 bit value actual=%0d expected=%0d", bit_dat_o, e);
                end
            end
        end
    end

    task automatic send_bit(input bit v, input int per);
        int hi;
        hi = v ? (per * 3) / 4 : per / 4;
        exp_bits.push_back(v);
        line_i = 1'b1;
        repeat (hi) @(negedge clk);
        line_i = 1'b0;
        repeat (per - hi) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int per);
        for (int i = 7; i >= 0; i--) send_bit(b[i], per);
    endtask

    task automatic quiet(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        check("R2 all sent bits strobed", exp_bits.size(), 0);
        exp_bits.delete();
        rst_n = 1'b0;
        quiet(3);
        rst_n = 1'b1;
        quiet(2);
    endtask

    task automatic read_byte(input string req, input logic [7:0] exp);
        check(req, rd_data_o, exp);
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        quiet(3);
        rst_n = 1'b1;
        quiet(2);

        // R10 reset state
        check("R10 idle after reset", line_idle_o, 1);
        check("R10 empty after reset", rd_empty_o, 1);
        check("R10 full after reset", rd_full_o, 0);
        check("R10 overflow after reset", overflow_o, 0);
        check("R10 strobe after reset", bit_clk_o, 0);
        check("R10 period after reset", cal_period_o, 100);

        // R1 R3 R4: two bytes at nominal rate
        send_byte(8'hA5, 100);
        check("R9 not idle mid-stream", line_idle_o, 0);
        send_byte(8'h3C, 100);
        quiet(300);
        check("R9 idle after gap", line_idle_o, 1);
        check("R4 not empty", rd_empty_o, 0);
        read_byte("R3 first byte msb-first", 8'hA5);
        read_byte("R4 second byte order", 8'h3C);
        check("R4 empty after reads", rd_empty_o, 1);
        check("R7 period stable at nominal", cal_period_o, 100);

        // R7 window boundary at 80 cycles
        do_reset();
        for (int i = 0; i < 8; i++) send_bit(i[0], 80);
        quiet(300);
        check("R7 seven measurements no update", cal_period_o, 100);
        for (int i = 0; i < 9; i++) send_bit(i[1], 80);
        quiet(300);
        check("R7 eight measurements update", cal_period_o, 80);
        for (int i = 0; i < 9; i++) send_bit(~i[0], 120);
        quiet(300);
        check("R7 retrack to 120", cal_period_o, 120);

        // R6 R8 out-of-range periods rejected
        for (int i = 0; i < 16; i++) send_bit(i[2] ^ i[0], 170);
        quiet(300);
        check("R8 period unchanged by rejected", cal_period_o, 120);
        check("R6 idle after long burst", line_idle_o, 1);

        // R9 partial byte kept across idle
        do_reset();
        send_byte(8'hF0, 100);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 100);
        quiet(300);
        check("R9 idle during partial byte", line_idle_o, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 100);
        quiet(300);
        read_byte("R3 byte F0", 8'hF0);
        read_byte("R9 byte spanning idle", 8'hF0);
        check("R4 empty", rd_empty_o, 1);

        // R5 overflow
        do_reset();
        for (int k = 0; k < 16; k++) send_byte(8'((k * 13 + 7) & 8'hFF), 100);
        quiet(300);
        check("R4 full at 16", rd_full_o, 1);
        check("R5 no overflow yet", overflow_o, 0);
        send_byte(8'hEE, 100);
        quiet(300);
        check("R5 overflow set", overflow_o, 1);
        for (int k = 0; k < 16; k++) read_byte("R5 stored bytes intact", 8'((k * 13 + 7) & 8'hFF));
        check("R5 extra byte discarded", rd_empty_o, 1);
        check("R5 overflow sticky", overflow_o, 1);
        check("R2 all sent bits strobed", exp_bits.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule